// File: doc/BRIEF.md
# Channel-Programmed Synthesizer Divider Chain

This block is the digital division path of a two-loop frequency synthesizer for a ten-channel cordless handset. A crystal clock is divided down to a fixed 5 kHz comparison reference. The same divider also produces a square 5 kHz guard tone. Two programmable counters, one for transmit and one for receive, are each clocked by a squared-up VCO input. Each counter emits a one-cycle pulse per divide period, and these pulses go to the phase detectors.

A 4-bit channel code and a base/remote mode bit select the divide ratios. Codes outside 1..9 fold onto channel 10. In base mode the receive ratios are a fixed table. The transmit table and the remote receive table are parameters. A new code takes effect only when a counter reloads. An active-low standby input freezes the transmit counter and leaves the receive path running.

Top module: `chan_pll_divider`

## Requirements
- R1: `ref_pulse_o` is high for exactly one crystal cycle every 2048 crystal cycles. The first pulse appears on the 2048th crystal edge after reset is released.
- R2: `guard_tone_o` is a square wave with a period of 2048 crystal cycles, high for 1024 and low for 1024. Its falling edge coincides with the cycle in which `ref_pulse_o` is high.
- R3: `chan_code_i` is read as an unsigned binary number with bit 3 as MSB. Codes 1..9 select channels 1..9, and codes 0 and 10..15 all select channel 10.
- R4: With `base_mode_i`=1, the receive divide ratio for channels 1..10 is 7795, 7830, 7833, 7815, 7836, 7827, 7839, 7847, 7859, 7855.
- R5: With `base_mode_i`=0, the receive ratio for channel n is entry n-1 of parameter `RX_REMOTE_TAB`. The defaults are 7183, 7187, 7195, 7203, 7207, 7215, 7227, 7235, 7247, 7255.
- R6: The transmit ratio for channel n is entry n-1 of `TX_BASE_TAB` (base mode) or `TX_REMOTE_TAB` (remote mode). The base defaults are 9322..9394 and the remote defaults are 9934..9994.
- R7: Each divider pulse is high for exactly one cycle of its own VCO clock, and the spacing between pulses equals the selected ratio in VCO cycles.
- R8: A change of channel code in the middle of a count does not alter the period in progress. The change applies from the next reload.
- R9: While `standby_n_i` is low, the transmit counter holds its value and `tx_div_pulse_o` stays low, while the receive pulses continue. After release, full transmit periods again equal the ratio.
- R10: While `rst_i` is high, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal_i | input | 1 | Crystal clock, 10.24 MHz nominal |
| rst_i | input | 1 | Synchronous active-high reset, sampled by every clock |
| vco_tx_i | input | 1 | Squared transmit VCO clock |
| vco_rx_i | input | 1 | Squared receive VCO clock |
| chan_code_i | input | 4 | Channel code |
| base_mode_i | input | 1 | 1 = base unit ratios, 0 = remote unit ratios |
| standby_n_i | input | 1 | Active-low standby for the transmit divider |
| ref_pulse_o | output | 1 | Comparison reference pulse (crystal domain) |
| guard_tone_o | output | 1 | 5 kHz square guard tone |
| tx_div_pulse_o | output | 1 | Transmit divider pulse (transmit VCO domain) |
| rx_div_pulse_o | output | 1 | Receive divider pulse (receive VCO domain) |

## Verification
The reference pulse is registered one crystal cycle after the counter reaches its last state. Each divider pulse appears in the VCO cycle that follows its reload edge, so a ratio change is visible in the pulse spacing only after the reload following the change. For each vector, the bench therefore lets two pulses pass before it times one full period. All outputs are sampled on the falling edge of their own clock, and every clock edge is phase-offset from the instants when inputs change. For the mid-count change, the code is altered 100 VCO cycles into a timed period. The bench then expects the old ratio for that period and the new ratio for the next one.

// File: rtl/chan_pll_pkg.sv
package chan_pll_pkg;

    localparam int NCH     = 10;
    localparam int RW      = 14;
    localparam int REF_DIV = 2048;
    localparam int REF_W   = $clog2(REF_DIV);
    localparam int IDX_W   = $clog2(NCH);

    typedef logic [RW-1:0]            ratio_t;
    typedef logic [NCH-1:0][RW-1:0]   ratio_tab_t;
    typedef logic [IDX_W-1:0]         chan_idx_t;

    typedef enum logic {
        UNIT_REMOTE = 1'b0,
        UNIT_BASE   = 1'b1
    } unit_e;

    typedef struct packed {
        ratio_t rx;
        ratio_t tx;
    } ratio_pair_t;

    // Entry 0 is channel 1; literals list channel 10 first.
    localparam ratio_tab_t RX_BASE_TAB = {
        14'd7855, 14'd7859, 14'd7847, 14'd7839, 14'd7827,
        14'd7836, 14'd7815, 14'd7833, 14'd7830, 14'd7795};

    localparam ratio_tab_t RX_REMOTE_DEF = {
        14'd7255, 14'd7247, 14'd7235, 14'd7227, 14'd7215,
        14'd7207, 14'd7203, 14'd7195, 14'd7187, 14'd7183};

    localparam ratio_tab_t TX_BASE_DEF = {
        14'd9394, 14'd9386, 14'd9374, 14'd9366, 14'd9354,
        14'd9346, 14'd9342, 14'd9334, 14'd9326, 14'd9322};

    localparam ratio_tab_t TX_REMOTE_DEF = {
        14'd9994, 14'd9998, 14'd9986, 14'd9978, 14'd9966,
        14'd9975, 14'd9954, 14'd9972, 14'd9969, 14'd9934};

    // Codes 1..9 map to channels 1..9, everything else folds to the top channel.
    function automatic chan_idx_t code_to_idx(input logic [3:0] code);
        if (code >= 4'd1 && code <= 4'(NCH - 1))
            return chan_idx_t'(code - 4'd1);
        else
            return chan_idx_t'(NCH - 1);
    endfunction

endpackage

// File: rtl/chan_decode.sv
module chan_decode
    import chan_pll_pkg::*;
#(
    parameter ratio_tab_t TX_BASE_TAB   = TX_BASE_DEF,
    parameter ratio_tab_t TX_REMOTE_TAB = TX_REMOTE_DEF,
    parameter ratio_tab_t RX_REMOTE_TAB = RX_REMOTE_DEF
) (
    input  logic [3:0]  code_i,
    input  unit_e       unit_i,
    output ratio_pair_t ratios_o
);

    chan_idx_t idx;

    always_comb begin
        idx = code_to_idx(code_i);
        if (unit_i == UNIT_BASE) begin
            ratios_o.rx = RX_BASE_TAB[idx];
            ratios_o.tx = TX_BASE_TAB[idx];
        end else begin
            ratios_o.rx = RX_REMOTE_TAB[idx];
            ratios_o.tx = TX_REMOTE_TAB[idx];
        end
    end

endmodule

// File: rtl/ref_div.sv
module ref_div
    import chan_pll_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output logic pulse_o,
    output logic tone_o
);

    logic [REF_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            pulse_o <= (cnt_q == REF_W'(REF_DIV - 1));
        end
    end

    // MSB of a power-of-two counter is a 50 % square wave at the wrap rate.
    assign tone_o = cnt_q[REF_W-1];

endmodule

// File: rtl/prog_div.sv
module prog_div
    import chan_pll_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   en_i,
    input  ratio_t ratio_i,
    output logic   pulse_o
);

    ratio_t cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else if (!en_i) begin
            pulse_o <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q   <= ratio_i - 1'b1;
            pulse_o <= 1'b1;
        end else begin
            cnt_q   <= cnt_q - 1'b1;
            pulse_o <= 1'b0;
        end
    end

endmodule

// File: rtl/chan_pll_divider.sv
module chan_pll_divider
    import chan_pll_pkg::*;
#(
    parameter ratio_tab_t TX_BASE_TAB   = TX_BASE_DEF,
    parameter ratio_tab_t TX_REMOTE_TAB = TX_REMOTE_DEF,
    parameter ratio_tab_t RX_REMOTE_TAB = RX_REMOTE_DEF
) (
    input  logic       clk_xtal_i,
    input  logic       rst_i,
    input  logic       vco_tx_i,
    input  logic       vco_rx_i,
    input  logic [3:0] chan_code_i,
    input  logic       base_mode_i,
    input  logic       standby_n_i,
    output logic       ref_pulse_o,
    output logic       guard_tone_o,
    output logic       tx_div_pulse_o,
    output logic       rx_div_pulse_o
);

    ratio_pair_t ratios;

    chan_decode #(
        .TX_BASE_TAB  (TX_BASE_TAB),
        .TX_REMOTE_TAB(TX_REMOTE_TAB),
        .RX_REMOTE_TAB(RX_REMOTE_TAB)
    ) u_decode (
        .code_i  (chan_code_i),
        .unit_i  (unit_e'(base_mode_i)),
        .ratios_o(ratios)
    );

    ref_div u_ref (
        .clk_i  (clk_xtal_i),
        .rst_i  (rst_i),
        .pulse_o(ref_pulse_o),
        .tone_o (guard_tone_o)
    );

    prog_div u_tx_div (
        .clk_i  (vco_tx_i),
        .rst_i  (rst_i),
        .en_i   (standby_n_i),
        .ratio_i(ratios.tx),
        .pulse_o(tx_div_pulse_o)
    );

    prog_div u_rx_div (
        .clk_i  (vco_rx_i),
        .rst_i  (rst_i),
        .en_i   (1'b1),
        .ratio_i(ratios.rx),
        .pulse_o(rx_div_pulse_o)
    );

endmodule

// File: rtl/chan_pll_divider_chk.sv
module chan_pll_divider_chk
    import chan_pll_pkg::*;
(
    input logic   clk_xtal_i,
    input logic   vco_tx_i,
    input logic   vco_rx_i,
    input logic   rst_i,
    input logic   standby_n_i,
    input logic   ref_pulse_o,
    input logic   guard_tone_o,
    input logic   tx_div_pulse_o,
    input logic   rx_div_pulse_o,
    input ratio_t tx_cnt
);

    // R1
    a_r1_ref_single: assert property (@(posedge clk_xtal_i) disable iff (rst_i)
        ref_pulse_o |=> !ref_pulse_o);

    // R2
    a_r2_tone_falls_at_ref: assert property (@(posedge clk_xtal_i) disable iff (rst_i)
        ref_pulse_o |-> $fell(guard_tone_o));

    // R7
    a_r7_rx_single: assert property (@(posedge vco_rx_i) disable iff (rst_i)
        rx_div_pulse_o |=> !rx_div_pulse_o);

    // R7
    a_r7_tx_single: assert property (@(posedge vco_tx_i) disable iff (rst_i)
        tx_div_pulse_o |=> !tx_div_pulse_o);

    // R9
    a_r9_tx_frozen: assert property (@(posedge vco_tx_i) disable iff (rst_i)
        !standby_n_i |=> ($stable(tx_cnt) && !tx_div_pulse_o));

    // R10
    a_r10_reset_quiet: assert property (@(posedge clk_xtal_i)
        $past(rst_i) |-> (!ref_pulse_o && !guard_tone_o));

endmodule

bind chan_pll_divider chan_pll_divider_chk u_chk (
    .clk_xtal_i    (clk_xtal_i),
    .vco_tx_i      (vco_tx_i),
    .vco_rx_i      (vco_rx_i),
    .rst_i         (rst_i),
    .standby_n_i   (standby_n_i),
    .ref_pulse_o   (ref_pulse_o),
    .guard_tone_o  (guard_tone_o),
    .tx_div_pulse_o(tx_div_pulse_o),
    .rx_div_pulse_o(rx_div_pulse_o),
    .tx_cnt        (u_tx_div.cnt_q)
);

// File: tb/chan_pll_divider_tb.sv
`timescale 1ns/10ps
module chan_pll_divider_tb;
    import chan_pll_pkg::*;

    localparam ratio_tab_t TB_TX_BASE = {
        14'd9394, 14'd9386, 14'd9374, 14'd9366, 14'd9354,
        14'd9346, 14'd9342, 14'd9334, 14'd9326, 14'd9322};
    localparam ratio_tab_t TB_TX_REM = {
        14'd9994, 14'd9998, 14'd9986, 14'd9978, 14'd9966,
        14'd9975, 14'd9954, 14'd9972, 14'd9969, 14'd9934};
    localparam ratio_tab_t TB_RX_REM = {
        14'd7255, 14'd7247, 14'd7235, 14'd7227, 14'd7215,
        14'd7207, 14'd7203, 14'd7195, 14'd7187, 14'd7183};

    typedef struct packed {
        logic        mode;
        logic [3:0]  code;
        logic [13:0] exp_rx;
        logic [13:0] exp_tx;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1,  14'd7795, 14'd9322},
        '{1'b1, 4'd2,  14'd7830, 14'd9326},
        '{1'b1, 4'd3,  14'd7833, 14'd9334},
        '{1'b1, 4'd4,  14'd7815, 14'd9342},
        '{1'b1, 4'd5,  14'd7836, 14'd9346},
        '{1'b1, 4'd6,  14'd7827, 14'd9354},
        '{1'b1, 4'd7,  14'd7839, 14'd9366},
        '{1'b1, 4'd8,  14'd7847, 14'd9374},
        '{1'b1, 4'd9,  14'd7859, 14'd9386},
        '{1'b1, 4'd10, 14'd7855, 14'd9394},
        '{1'b1, 4'd11, 14'd7855, 14'd9394},
        '{1'b1, 4'd12, 14'd7855, 14'd9394},
        '{1'b1, 4'd13, 14'd7855, 14'd9394},
        '{1'b1, 4'd14, 14'd7855, 14'd9394},
        '{1'b1, 4'd15, 14'd7855, 14'd9394},
        '{1'b1, 4'd0,  14'd7855, 14'd9394},
        '{1'b0, 4'd0,  14'd7255, 14'd9994},
        '{1'b0, 4'd3,  14'd7195, 14'd9972},
        '{1'b0, 4'd7,  14'd7227, 14'd9978},
        '{1'b0, 4'd9,  14'd7247, 14'd9998},
        '{1'b0, 4'd13, 14'd7255, 14'd9994}
    };

    logic       clk = 1'b0;
    logic       vco_tx = 1'b0;
    logic       vco_rx = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] code = 4'd1;
    logic       mode = 1'b1;
    logic       sb_n = 1'b1;
    logic       ref_p, tone, tx_p, rx_p;

    int n_chk = 0;
    int n_bad = 0;
    int wd    = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;
    initial begin #0.3;  forever #1   vco_rx = ~vco_rx; end
    initial begin #0.55; forever #0.8 vco_tx = ~vco_tx; end

    chan_pll_divider #(
        .TX_BASE_TAB  (TB_TX_BASE),
        .TX_REMOTE_TAB(TB_TX_REM),
        .RX_REMOTE_TAB(TB_RX_REM)
    ) u_dut (
        .clk_xtal_i    (clk),
        .rst_i         (rst),
        .vco_tx_i      (vco_tx),
        .vco_rx_i      (vco_rx),
        .chan_code_i   (code),
        .base_mode_i   (mode),
        .standby_n_i   (sb_n),
        .ref_pulse_o   (ref_p),
        .guard_tone_o  (tone),
        .tx_div_pulse_o(tx_p),
        .rx_div_pulse_o(rx_p)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rx_wait();
        do @(negedge vco_rx); while (!rx_p);
    endtask

    task automatic tx_wait();
        do @(negedge vco_tx); while (!tx_p);
    endtask

    task automatic rx_period(output int n);
        n = 0;
        do begin @(negedge vco_rx); n++; end while (!rx_p);
    endtask

    task automatic tx_period(output int n);
        n = 0;
        do begin @(negedge vco_tx); n++; end while (!tx_p);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd >= 195000 && !done) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", wd);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int n, hi, prev_tone, rxn, txn, rxc, txc;

        // R10: reset state
        repeat (20) @(negedge clk);
        check("R10 ref_pulse in reset", ref_p, 0);
        check("R10 guard_tone in reset", tone, 0);
        check("R10 tx pulse in reset", tx_p, 0);
        check("R10 rx pulse in reset", rx_p, 0);
        rst = 1'b0;

        // R1: first reference pulse and period
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_p);
        check("R1 first ref pulse delay", n, 2048);
        n = 0; hi = 0; prev_tone = 0;
        do begin
            prev_tone = tone;
            @(negedge clk);
            n++;
            if (tone) hi++;
        end while (!ref_p);
        check("R1 ref period", n, 2048);
        check("R2 tone high cycles", hi, 1024);
        check("R2 tone low at ref pulse", tone, 0);
        check("R2 tone high before ref pulse", prev_tone, 1);
        @(negedge clk);
        check("R1 ref pulse one cycle", ref_p, 0);

        // R3 R4 R5 R6 R7: vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mode = VECS[v].mode;
            code = VECS[v].code;
            fork
                begin rx_wait(); rx_wait(); rx_period(rxn); end
                begin tx_wait(); tx_wait(); tx_period(txn); end
            join
            check($sformatf("%s R3 R7 rx ratio code %0d", VECS[v].mode ? "R4" : "R5",
                            VECS[v].code), rxn, int'(VECS[v].exp_rx));
            check($sformatf("R6 R3 R7 tx ratio mode %0d code %0d", VECS[v].mode,
                            VECS[v].code), txn, int'(VECS[v].exp_tx));
        end

        // R8: code change mid-count
        @(negedge clk);
        mode = 1'b1;
        code = 4'd1;
        rx_wait(); rx_wait();
        n = 0;
        do begin
            @(negedge vco_rx);
            n++;
            if (n == 100) code = 4'd5;
        end while (!rx_p);
        check("R8 period in progress keeps old ratio", n, 7795);
        rx_period(n);
        check("R8 next period uses new ratio", n, 7836);

        // R9: standby freezes transmit only
        @(negedge clk);
        code = 4'd1;
        tx_wait(); tx_wait();
        @(negedge clk);
        sb_n = 1'b0;
        @(negedge clk);
        rxc = 0; txc = 0;
        fork
            begin repeat (1500) @(negedge clk); end
            begin forever begin @(negedge vco_rx); if (rx_p) rxc++; end end
            begin forever begin @(negedge vco_tx); if (tx_p) txc++; end end
        join_any
        disable fork;
        check("R9 no tx pulses in standby", txc, 0);
        check("R9 rx keeps running in standby", (rxc >= 1) ? 1 : 0, 1);
        @(negedge clk);
        sb_n = 1'b1;
        tx_wait();
        tx_period(n);
        check("R9 tx period after release", n, 9322);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule